// File: doc/BRIEF.md
# Multi-mode reload pulse timer

This block is a down-counting timer with two reload registers and an output flip-flop that inverts on chosen events. It has three modes. In the PWM mode the two reload values take turns, so the high and low times of the output are set separately. In the single-shot mode the block gives one pulse and then stops. In the delayed single-shot mode it waits first for a time set by a preset value of the counter, then gives one pulse. The counter only moves on cycles where a count strobe is high. The strobe comes from a prescaler in the same clock domain. The prescaler sits outside this block.

Software writes the block through a simple write port with a two-bit select. It can start the timer by setting the enable bit of the control word. An external start input can also start the timer: it passes through a synchronizer and a rising-edge detector. The single-shot modes disarm themselves when they finish. An interrupt request is a one-cycle pulse. It is raised on the 2nd, 4th, 6th and later underflows in PWM mode. In the single-shot modes it is raised on each underflow.

The controller is a state machine with three states:
- `ST_IDLE`: stopped.
- `ST_PRIME`: armed and waiting for the count strobe that loads reload 0.
- `ST_COUNT`: counting.

Its transitions are:
- T_GO_PRIME: `ST_IDLE` to `ST_PRIME`, on a start in PWM or single-shot mode.
- T_GO_COUNT: `ST_IDLE` to `ST_COUNT`, on a start in delayed mode.
- T_LOAD: `ST_PRIME` to `ST_COUNT`, on the first strobe.
- T_END: `ST_COUNT` to `ST_IDLE`, on the last underflow of a single-shot run.
- T_STOP: any running state to `ST_IDLE`, on a software disable.

Top module: `rpt_timer`

## Requirements
- R1: After reset, `tmr_out`, `irq` and `run_flag` are 0 and `count_val` is 0.
- R2: The counter and `tmr_out` change only on cycles where `cnt_tick` is high. While running, a strobe with the counter above 0 lowers it by exactly one.
- R3: In PWM mode (mode 0) and single-shot mode (mode 1), the first strobe after a start loads reload 0 into the counter and inverts `tmr_out`.
- R4: In PWM mode, a strobe with the counter at 0 is an underflow. It inverts `tmr_out` and reloads the counter instead of wrapping. The first underflow loads reload 1, and later underflows load reload 0 and reload 1 in turn. The output phases therefore last reload 0 + 1 and reload 1 + 1 strobes, one after the other.
- R5: In PWM mode, `irq` pulses for one cycle on the 2nd, 4th, 6th and later underflows, and on no other cycle. Every `irq` pulse comes in the same cycle as an inversion of `tmr_out`.
- R6: In single-shot mode, `tmr_out` goes through one pulse of reload 0 + 1 strobes. `irq` pulses at the underflow that ends it, and `run_flag` clears in that same cycle. No further inversion follows until the timer is started again.
- R7: In delayed single-shot mode (mode 2), counting starts from the preset counter value. The first underflow inverts `tmr_out`, pulses `irq` and loads reload 0. The second underflow inverts `tmr_out`, pulses `irq` and stops the timer. This gives a delay of preset + 1 strobes, then a pulse of reload 0 + 1 strobes.
- R8: Writing the control word with enable 0 while running clears `run_flag` on that edge, without waiting for the period to end. After that, strobes change neither `count_val` nor `tmr_out`.
- R9: A rising edge on `ext_start` starts a stopped timer in the stored mode. It passes two synchronizer flops and an edge detector, so `run_flag` rises on the third clock edge after the first edge that samples `ext_start` high.
- R10: Register select: 0 is the counter preset, 1 is reload 0, 2 is reload 1, 3 is the control word. A counter preset write (select 0) is ignored while the timer runs and is taken while it is stopped.
- R11: The control word holds the mode in bits 1:0 and the enable bit in bit 2. Mode value 3 is reserved. Enabling with it leaves the timer stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_tick | input | 1 | Count strobe, one system clock wide |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select (0 preset, 1 reload 0, 2 reload 1, 3 control) |
| wr_data | input | CNT_W | Write data; control word uses bits 2:0 |
| ext_start | input | 1 | Asynchronous external start request |
| tmr_out | output | 1 | Output flip-flop waveform |
| irq | output | 1 | Interrupt request pulse |
| run_flag | output | 1 | Enable state, high while the timer runs |
| count_val | output | CNT_W | Current counter value |

## Verification
The bench builds the block with its default parameters: a 16-bit counter and a two-stage start synchronizer. These defaults keep the exact synchronizer latency of R9 observable at the edges. The stimulus uses small preset and reload values, down to zero. With these values, every PWM alternation, both single-shot endings and the one-strobe minimum pulse fit into short windows. A strobe held high every cycle lines up each inversion and interrupt with a known cycle number. Sparse strobes then show that nothing moves between them.

// File: rtl/rpt_pkg.sv
package rpt_pkg;

    typedef enum logic [1:0] {
        MODE_PWM = 2'd0,
        MODE_ONE = 2'd1,
        MODE_DLY = 2'd2,
        MODE_RSV = 2'd3
    } mode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PRIME = 2'd1,
        ST_COUNT = 2'd2
    } state_e;

    typedef enum logic [1:0] {
        CC_HOLD  = 2'd0,
        CC_DEC   = 2'd1,
        CC_LD_R0 = 2'd2,
        CC_LD_R1 = 2'd3
    } cnt_cmd_e;

    localparam logic [1:0] SEL_PRESET = 2'd0;
    localparam logic [1:0] SEL_RLD0   = 2'd1;
    localparam logic [1:0] SEL_RLD1   = 2'd2;
    localparam logic [1:0] SEL_CTRL   = 2'd3;

    localparam int CTRL_EN_BIT = 2;

endpackage

// File: rtl/rpt_start_sync.sv
module rpt_start_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);

    localparam int LAST = STAGES;

    logic [LAST:0] sr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else begin
            sr_q <= {sr_q[LAST-1:0], din};
        end
    end

    assign rise = sr_q[LAST-1] & ~sr_q[LAST];

    // R9
    rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);

endmodule

// File: rtl/rpt_down_counter.sv
module rpt_down_counter
    import rpt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             preset_ok,
    input  cnt_cmd_e         cmd,
    output logic [CNT_W-1:0] cnt_q,
    output logic             is_zero
);

    logic [CNT_W-1:0] rld0_q;
    logic [CNT_W-1:0] rld1_q;
    logic             preset_wr;

    assign preset_wr = wr_en && (wr_sel == SEL_PRESET) && preset_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rld0_q <= '0;
            rld1_q <= '0;
        end else if (wr_en) begin
            if (wr_sel == SEL_RLD0) rld0_q <= wr_data;
            if (wr_sel == SEL_RLD1) rld1_q <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            unique case (cmd)
                CC_HOLD:  if (preset_wr) cnt_q <= wr_data;
                CC_DEC:   cnt_q <= cnt_q - 1'b1;
                CC_LD_R0: cnt_q <= rld0_q;
                CC_LD_R1: cnt_q <= rld1_q;
                default:  cnt_q <= cnt_q;
            endcase
        end
    end

    assign is_zero = (cnt_q == '0);

    // R2
    dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CC_DEC) |=> (cnt_q == $past(cnt_q) - 1'b1));

    // R10
    preset_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!preset_ok && cmd == CC_HOLD) |=> $stable(cnt_q));

endmodule

// File: rtl/rpt_ctrl_fsm.sv
module rpt_ctrl_fsm
    import rpt_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     tick,
    input  logic     is_zero,
    input  logic     ctrl_wr,
    input  logic     ctrl_en,
    input  logic [1:0] ctrl_mode,
    input  logic     ext_rise,
    output cnt_cmd_e cmd,
    output logic     tmr_out,
    output logic     irq,
    output logic     run_flag,
    output logic     preset_ok
);

    state_e state_q;
    state_e state_d;
    mode_e  mode_q;
    mode_e  eff_mode;
    logic   phase_q;

    logic go;
    logic stop_sw;
    logic load_tick;
    logic uf;
    logic last_uf;

    // mode used by a start request: a control write in the same cycle wins
    assign eff_mode  = (state_q == ST_IDLE && ctrl_wr) ? mode_e'(ctrl_mode) : mode_q;
    assign go        = (state_q == ST_IDLE) && ((ctrl_wr && ctrl_en) || ext_rise)
                       && (eff_mode != MODE_RSV);
    assign stop_sw   = (state_q != ST_IDLE) && ctrl_wr && !ctrl_en;
    assign load_tick = (state_q == ST_PRIME) && tick && !stop_sw;
    assign uf        = (state_q == ST_COUNT) && tick && is_zero && !stop_sw;
    assign last_uf   = uf && ((mode_q == MODE_ONE) || (mode_q == MODE_DLY && phase_q));

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (go) state_d = (eff_mode == MODE_DLY) ? ST_COUNT : ST_PRIME; // T_GO_COUNT / T_GO_PRIME
            end
            ST_PRIME: begin
                if (stop_sw)        state_d = ST_IDLE;   // T_STOP
                else if (load_tick) state_d = ST_COUNT;  // T_LOAD
            end
            ST_COUNT: begin
                if (stop_sw)      state_d = ST_IDLE;     // T_STOP
                else if (last_uf) state_d = ST_IDLE;     // T_END
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // counter command
    always_comb begin
        cmd = CC_HOLD;
        if (load_tick) begin
            cmd = CC_LD_R0;
        end else if (state_q == ST_COUNT && tick && !stop_sw) begin
            if (!is_zero) begin
                cmd = CC_DEC;
            end else begin
                unique case (mode_q)
                    MODE_PWM: cmd = phase_q ? CC_LD_R0 : CC_LD_R1;
                    MODE_DLY: cmd = phase_q ? CC_HOLD : CC_LD_R0;
                    default:  cmd = CC_HOLD;
                endcase
            end
        end
    end

    // state register with the mode latch and the reload phase
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            mode_q  <= MODE_PWM;
            phase_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && ctrl_wr) mode_q <= eff_mode;
            if (go)      phase_q <= 1'b0;
            else if (uf) phase_q <= (mode_q == MODE_PWM) ? ~phase_q : 1'b1;
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_out <= 1'b0;
            irq     <= 1'b0;
        end else begin
            if (load_tick || uf) tmr_out <= ~tmr_out;
            irq <= uf && ((mode_q != MODE_PWM) || phase_q);
        end
    end

    assign run_flag  = (state_q != ST_IDLE);
    assign preset_ok = (state_q == ST_IDLE);

    // R2
    toggle_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tmr_out) |-> $past(tick));

    // R5
    irq_with_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !$stable(tmr_out));

    // R6
    shot_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && mode_q == MODE_ONE) |-> !run_flag);

    // R7
    dly_second_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && mode_q == MODE_DLY && $past(phase_q)) |-> !run_flag);

    // R8
    idle_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == ST_IDLE && state_q == ST_IDLE) |-> $stable(tmr_out));

    // R11
    rsv_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && ctrl_wr && ctrl_en && ctrl_mode == 2'd3 && !ext_rise)
        |=> (state_q == ST_IDLE));

endmodule

// File: rtl/rpt_timer.sv
module rpt_timer
    import rpt_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_tick,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             ext_start,
    output logic             tmr_out,
    output logic             irq,
    output logic             run_flag,
    output logic [CNT_W-1:0] count_val
);

    logic     ext_rise;
    logic     is_zero;
    logic     preset_ok;
    logic     ctrl_wr;
    cnt_cmd_e cmd;

    assign ctrl_wr = wr_en && (wr_sel == SEL_CTRL);

    rpt_start_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (ext_start),
        .rise  (ext_rise)
    );

    rpt_ctrl_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (cnt_tick),
        .is_zero   (is_zero),
        .ctrl_wr   (ctrl_wr),
        .ctrl_en   (wr_data[CTRL_EN_BIT]),
        .ctrl_mode (wr_data[1:0]),
        .ext_rise  (ext_rise),
        .cmd       (cmd),
        .tmr_out   (tmr_out),
        .irq       (irq),
        .run_flag  (run_flag),
        .preset_ok (preset_ok)
    );

    rpt_down_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .preset_ok (preset_ok),
        .cmd       (cmd),
        .cnt_q     (count_val),
        .is_zero   (is_zero)
    );

endmodule

// File: tb/rpt_timer_tb.sv
module rpt_timer_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WINDOW     = 60;
    localparam int NVEC       = 6;

    // {mode, preset, reload0, reload1}
    localparam logic [49:0] VEC [NVEC] = '{
        {2'd1, 16'd0, 16'd0, 16'd0},
        {2'd1, 16'd0, 16'd5, 16'd0},
        {2'd2, 16'd0, 16'd0, 16'd0},
        {2'd2, 16'd3, 16'd7, 16'd0},
        {2'd0, 16'd0, 16'd2, 16'd4},
        {2'd0, 16'd0, 16'd0, 16'd1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnt_tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic        ext_start = 1'b0;
    logic        tmr_out;
    logic        irq;
    logic        run_flag;
    logic [15:0] count_val;

    int n_total = 0;
    int n_pass  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rpt_timer u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt_tick  (cnt_tick),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .ext_start (ext_start),
        .tmr_out   (tmr_out),
        .irq       (irq),
        .run_flag  (run_flag),
        .count_val (count_val)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_total++;
        if (ok) n_pass++;
        else $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    endtask

    task automatic wr(input logic [1:0] sel, input logic [15:0] data);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_sel  = sel;
        wr_data = data;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    // expected event at cycle c after the enabling edge: inversion, or irq when want_irq
    function automatic bit exp_evt(input int mode, input int p, input int r0, input int r1,
                                   input int c, input bit want_irq);
        int t = (mode == 2) ? p + 1 : 1;
        int k = (mode == 2) ? 1 : 0;
        int kmax = (mode == 0) ? 1000 : (mode == 1 ? 1 : 2);
        while (t <= c && k <= kmax) begin
            if (t == c) begin
                if (!want_irq) return 1'b1;
                if (mode == 0) return (k >= 2) && (k % 2 == 0);
                if (mode == 1) return k == 1;
                return k >= 1;
            end
            if (mode == 0) t += (k % 2 == 0) ? r0 + 1 : r1 + 1;
            else           t += r0 + 1;
            k++;
        end
        return 1'b0;
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_total++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("%0d/%0d checks passed", n_pass, n_total);
            $finish;
        end
    end

    initial begin
        logic        o;
        logic [15:0] cv;
        step(3);
        @(negedge clk);
        rst_n = 1'b1;
        step(1);

        // R1 reset state
        chk(tmr_out == 1'b0,    "R1 tmr_out", int'(tmr_out), 0);
        chk(irq == 1'b0,        "R1 irq", int'(irq), 0);
        chk(run_flag == 1'b0,   "R1 run_flag", int'(run_flag), 0);
        chk(count_val == 16'd0, "R1 count_val", int'(count_val), 0);

        // vector table: strobe every cycle, compare each cycle with the expected event list
        for (int v = 0; v < NVEC; v++) begin
            int md, p, r0, r1, bad_t, bad_i, first_t, first_i;
            string rq;
            logic prev;
            md = int'(VEC[v][49:48]);
            p  = int'(VEC[v][47:32]);
            r0 = int'(VEC[v][31:16]);
            r1 = int'(VEC[v][15:0]);
            rq = (md == 0) ? "R4" : (md == 1 ? "R6" : "R7");
            @(negedge clk);
            cnt_tick = 1'b1;
            wr(2'd0, 16'(p));
            wr(2'd1, 16'(r0));
            wr(2'd2, 16'(r1));
            prev = tmr_out;
            wr(2'd3, 16'(4 + md));
            bad_t = 0; bad_i = 0; first_t = -1; first_i = -1;
            for (int c = 1; c <= WINDOW; c++) begin
                @(posedge clk);
                #1;
                if ((tmr_out != prev) != exp_evt(md, p, r0, r1, c, 1'b0)) begin
                    bad_t++;
                    if (first_t < 0) first_t = c;
                end
                if (irq != exp_evt(md, p, r0, r1, c, 1'b1)) begin
                    bad_i++;
                    if (first_i < 0) first_i = c;
                end
                prev = tmr_out;
            end
            // R3 R4 R6 R7: inversion timing
            chk(bad_t == 0, {rq, " inversion timing (first bad cycle as actual)"}, first_t, -1);
            // R5 R6 R7: interrupt timing
            chk(bad_i == 0, {(md == 0) ? "R5" : rq, " irq timing (first bad cycle as actual)"}, first_i, -1);
            chk(run_flag == (md == 0), {rq, " run_flag at end of window"}, int'(run_flag), int'(md == 0));
            wr(2'd3, 16'(md));
            @(negedge clk);
            cnt_tick = 1'b0;
        end

        // R2 R3: armed with no strobe, nothing moves; first strobe loads reload 0 and inverts
        o  = tmr_out;
        cv = count_val;
        wr(2'd1, 16'd5);
        wr(2'd3, 16'h0005);
        step(4);
        chk(run_flag == 1'b1 && count_val == cv && tmr_out == o, "R2 hold without strobe",
            int'(count_val), int'(cv));
        @(negedge clk); cnt_tick = 1'b1;
        @(posedge clk); #1;
        @(negedge clk); cnt_tick = 1'b0;
        chk(count_val == 16'd5, "R3 load of reload 0", int'(count_val), 5);
        chk(tmr_out == ~o, "R3 inversion at start", int'(tmr_out), int'(~o));
        step(3);
        chk(count_val == 16'd5, "R2 hold between strobes", int'(count_val), 5);
        @(negedge clk); cnt_tick = 1'b1;
        @(posedge clk); #1;
        @(negedge clk); cnt_tick = 1'b0;
        chk(count_val == 16'd4, "R2 single decrement", int'(count_val), 4);

        // R10: preset write ignored while running
        wr(2'd0, 16'h00AA);
        chk(count_val == 16'd4, "R10 preset ignored while running", int'(count_val), 4);

        // R8: software disable stops at once; strobes afterwards change nothing
        wr(2'd3, 16'h0001);
        chk(run_flag == 1'b0, "R8 run_flag cleared", int'(run_flag), 0);
        o = tmr_out;
        @(negedge clk); cnt_tick = 1'b1;
        step(5);
        @(negedge clk); cnt_tick = 1'b0;
        chk(count_val == 16'd4 && tmr_out == o, "R8 frozen after disable", int'(count_val), 4);

        // R10: preset write taken while stopped
        wr(2'd0, 16'd9);
        chk(count_val == 16'd9, "R10 preset taken while stopped", int'(count_val), 9);

        // R11: reserved mode refuses to start
        @(negedge clk); cnt_tick = 1'b1;
        wr(2'd3, 16'h0007);
        step(2);
        chk(run_flag == 1'b0 && count_val == 16'd9, "R11 reserved mode stays stopped",
            int'(run_flag), 0);
        @(negedge clk); cnt_tick = 1'b0;

        // R8: stop in the middle of a PWM period
        wr(2'd1, 16'd3);
        wr(2'd2, 16'd3);
        @(negedge clk); cnt_tick = 1'b1;
        wr(2'd3, 16'h0004);
        step(6);
        wr(2'd3, 16'h0000);
        chk(run_flag == 1'b0, "R8 PWM stop at once", int'(run_flag), 0);
        cv = count_val;
        o  = tmr_out;
        step(5);
        chk(count_val == cv && tmr_out == o, "R8 PWM frozen after stop", int'(count_val), int'(cv));
        @(negedge clk); cnt_tick = 1'b0;

        // R9: external start through the synchronizer
        wr(2'd3, 16'h0001);
        @(negedge clk); ext_start = 1'b1;
        @(posedge clk); #1;
        chk(run_flag == 1'b0, "R9 not started after edge 1", int'(run_flag), 0);
        @(negedge clk); ext_start = 1'b0;
        @(posedge clk); #1;
        chk(run_flag == 1'b0, "R9 not started after edge 2", int'(run_flag), 0);
        @(posedge clk); #1;
        chk(run_flag == 1'b1, "R9 started on edge 3", int'(run_flag), 1);
        wr(2'd3, 16'h0001);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_pass, n_total);
        $finish;
    end

endmodule